// File: doc/BRIEF.md
# Seven-Way Majority Voter with Symmetric Condensation

This block takes seven one-bit votes and reports whether a strict majority of them, at least four, are 1. The datapath has no registers. The first four votes are not fed straight into a threshold network. They are first reduced to four signals, the elementary symmetric functions of those votes over GF(2), each written as an XOR of AND terms. A small threshold stage then combines these four condensed signals with the three remaining votes. After condensation, the first four votes play no further part in the logic.

Votes and results move as a single-beat stream. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The result beat is offered in the same cycle as the vote beat. Back-pressure passes straight through the block: `in_ready` equals `out_ready`, and `out_valid` equals `in_valid`. An upstream source that is stalled must hold `in_votes` steady. While it does, `out_major` stays steady too. The block holds no storage and cannot drop a beat or duplicate one.

The clock is used only to define the moment a beat is transferred. Vote bit 0 is the first condensed input, bits 3..0 form the condensed group, and bits 6..4 form the remaining group.

Top module: `sym_majority7`

## Requirements
- R1: `out_major` is 1 exactly when at least four bits of `in_votes` are 1, for all 128 vote patterns.
- R2: When bits 6..4 are all 1, `out_major` equals the OR of bits 3..0.
- R3: When exactly two of bits 6..4 are 1, `out_major` is 1 exactly when at least two of bits 3..0 are 1.
- R4: When exactly one of bits 6..4 is 1, `out_major` is 1 exactly when at least three of bits 3..0 are 1.
- R5: When bits 6..4 are all 0, `out_major` is 1 only when bits 3..0 are all 1.
- R6: `out_valid` equals `in_valid` in the same cycle. With `in_valid` low, `out_valid` is low.
- R7: `in_ready` equals `out_ready` in the same cycle, so a stalled consumer stalls the producer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that marks beat transfers |
| in_valid | input | 1 | Vote beat is present |
| in_ready | output | 1 | Block can take a vote beat |
| in_votes | input | 7 | Seven votes; bits 3..0 are condensed, bits 6..4 are the remaining group |
| out_valid | output | 1 | Result beat is present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_major | output | 1 | 1 when four or more votes are 1 |

## Verification
A wrong condensed signal does not show up on every input. It appears only on vote patterns that reach the faulty threshold term. For example, a bad third-order term shows only when exactly three of the first four votes are 1 and at least one remaining vote is 1. Because the result path holds no state, any such error appears on `out_major` in the same cycle as the offending votes. Sweeping all 128 patterns therefore exposes every single-term fault. Grouping the patterns by how many of the remaining three votes are set points each mismatch to one branch of the threshold stage.

// File: rtl/sym_maj_pkg.sv
package sym_maj_pkg;
  localparam int unsigned HEAD_W = 4;
  localparam int unsigned REST_W = 3;
  localparam int unsigned VOTE_W = HEAD_W + REST_W;
  localparam int unsigned THRESH = 4;

  typedef struct packed {
    logic s4;
    logic s3;
    logic s2;
    logic s1;
  } sym_t;
endpackage

// File: rtl/sym_condense.sv
module sym_condense
  import sym_maj_pkg::*;
(
  input  logic [HEAD_W-1:0] head,
  output sym_t              sym
);
  logic p1, p2, p3, p4;

  always_comb begin
    p1 = 1'b0;
    p2 = 1'b0;
    p3 = 1'b0;
    p4 = 1'b1;
    for (int i = 0; i < HEAD_W; i++) begin
      p1 = p1 ^ head[i];
      p4 = p4 & head[i];
      for (int j = i + 1; j < HEAD_W; j++) begin
        p2 = p2 ^ (head[i] & head[j]);
        for (int k = j + 1; k < HEAD_W; k++) begin
          p3 = p3 ^ (head[i] & head[j] & head[k]);
        end
      end
    end
  end

  assign sym = '{s4: p4, s3: p3, s2: p2, s1: p1};
endmodule

// File: rtl/rest_tally.sv
module rest_tally
  import sym_maj_pkg::*;
(
  input  logic [REST_W-1:0] rest,
  output logic              ge1,
  output logic              ge2,
  output logic              ge3
);
  assign ge1 = |rest;
  assign ge2 = (rest[0] & rest[1]) | (rest[0] & rest[2]) | (rest[1] & rest[2]);
  assign ge3 = &rest;
endmodule

// File: rtl/vote_threshold.sv
module vote_threshold
  import sym_maj_pkg::*;
(
  input  sym_t sym,
  input  logic ge1,
  input  logic ge2,
  input  logic ge3,
  output logic vote
);
  logic head_four, head_three, head_two, head_one;

  // head count recovered from the condensed signals alone
  assign head_four  = sym.s4;
  assign head_three = sym.s3;
  assign head_two   = sym.s2 & ~sym.s3;
  assign head_one   = sym.s1 & ~sym.s2;

  assign vote = head_four
              | (head_three & ge1)
              | (head_two   & ge2)
              | (head_one   & ge3);
endmodule

// File: rtl/sym_majority7.sv
module sym_majority7
  import sym_maj_pkg::*;
(
  input  logic              clk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VOTE_W-1:0] in_votes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_major
);
  sym_t sym;
  logic ge1, ge2, ge3;

  sym_condense u_condense (
    .head (in_votes[HEAD_W-1:0]),
    .sym  (sym)
  );

  rest_tally u_tally (
    .rest (in_votes[VOTE_W-1:HEAD_W]),
    .ge1  (ge1),
    .ge2  (ge2),
    .ge3  (ge3)
  );

  vote_threshold u_thresh (
    .sym  (sym),
    .ge1  (ge1),
    .ge2  (ge2),
    .ge3  (ge3),
    .vote (out_major)
  );

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/sym_majority7_chk.sv
module sym_majority7_chk
  import sym_maj_pkg::*;
(
  input logic              clk,
  input logic              in_valid,
  input logic              in_ready,
  input logic [VOTE_W-1:0] in_votes,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_major
);
  int unsigned head_n;
  int unsigned rest_n;

  always_comb begin
    head_n = $countones(in_votes[HEAD_W-1:0]);
    rest_n = $countones(in_votes[VOTE_W-1:HEAD_W]);
  end

  always_ff @(negedge clk) begin
    assert_threshold_R1: assert (out_major == ((head_n + rest_n) >= THRESH));
    if (rest_n == 3) begin
      assert_rest3_R2: assert (out_major == (head_n >= 1));
    end
    if (rest_n == 2) begin
      assert_rest2_R3: assert (out_major == (head_n >= 2));
    end
    if (rest_n == 1) begin
      assert_rest1_R4: assert (out_major == (head_n >= 3));
    end
    if (rest_n == 0) begin
      assert_rest0_R5: assert (out_major == (head_n == 4));
    end
  end
endmodule

bind sym_majority7 sym_majority7_chk u_chk (.*);

// File: tb/test_sym_majority7.sv
module test_sym_majority7;
  logic       clk = 1'b0;
  logic       in_valid;
  logic       in_ready;
  logic [6:0] in_votes;
  logic       out_valid;
  logic       out_ready;
  logic       out_major;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit exp_q[$];

  always #5 clk = ~clk;

  sym_majority7 i_sym_majority7 (
    .clk       (clk),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_votes  (in_votes),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_major (out_major)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d votes=%b", req, act, exp, in_votes);
    end
  endtask

  // consumer stalls on every third cycle
  initial begin
    int cyc = 0;
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = (cyc % 3) != 0;
    end
  end

  // monitor: scoreboard pop on each transfer, handshake checks every cycle
  always @(negedge clk) begin
    check("R7 in_ready", int'(in_ready), int'(out_ready));
    check("R6 out_valid", int'(out_valid), int'(in_valid));
    if (out_valid && out_ready) begin
      int rn;
      string tag;
      bit exp;
      rn = $countones(in_votes[6:4]);
      case (rn)
        3: tag = "R1/R2";
        2: tag = "R1/R3";
        1: tag = "R1/R4";
        default: tag = "R1/R5";
      endcase
      if (exp_q.size() == 0) begin
        check("R1 empty scoreboard", 1, 0);
      end else begin
        exp = exp_q.pop_front();
        check(tag, int'(out_major), int'(exp));
      end
    end
  end

  // driver
  initial begin
    in_valid = 1'b0;
    in_votes = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int v = 0; v < 128; v++) begin
      in_votes = v[6:0];
      in_valid = 1'b1;
      exp_q.push_back($countones(v[6:0]) >= 4);
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
      if (v % 16 == 15) begin
        in_valid = 1'b0;
        in_votes = 7'h7f;
        @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    wait (done);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule